// File: doc/BRIEF.md
# Multiframe Timebase with Sync Flywheel

This block keeps the bit, time-slot and frame position of a serial system bus whose multiframe is 48 frames long, one frame per 125 µs, so the pattern repeats every 6 ms. The frame length in bus clocks is a parameter: 193 for T1-style framing, 256 for E1-style framing. The position advances once per bus clock. Three indices come out: bit within slot, slot within frame and frame within multiframe. Two one-cycle strobes also come out, one at the start of every frame and one at the start of every multiframe.

A single direction select decides how the multiframe sync pin is used. In drive direction the block produces a one-clock pulse at frame 0 and at a programmable bit position within that frame. This position is called the sync offset. In listen direction the block watches the sync input for a low-to-high transition. On that edge it jumps to the sync offset in frame 0. Between edges, and when edges stop, the counters keep running on their own. A system bus that supplies this multiframe sync therefore needs no separate frame sync.

Top module: `mf_timebase`

## Requirements
- R1: While reset is held and on the first sample after it, bit_idx, slot_idx and frame_idx read 0 and frame_start and mfrm_start are both 1.
- R2: The in-frame position p advances by one per clock from 0 to FRAME_BITS-1 and then wraps to 0. bit_idx equals p mod 8 and slot_idx equals p div 8. frame_idx increases by one on each wrap of p and goes from 47 back to 0.
- R3: frame_start is 1 in exactly the cycles where p is 0. This gives a one-cycle pulse every FRAME_BITS clocks.
- R4: mfrm_start is 1 in exactly the cycles where p is 0 and frame_idx is 0. This gives one pulse every 48 × FRAME_BITS clocks.
- R5: With sync_dir = 0 (drive), sync_out is 1 for exactly one clock per multiframe. That clock is the one where frame_idx is 0 and p equals the sync offset.
- R6: A sync_offset value above FRAME_BITS-1 is treated as FRAME_BITS-1. This applies both to the output pulse position and to the realignment target.
- R7: With sync_dir = 1 (listen), sync_out stays 0.
- R8: With sync_dir = 1, a low-to-high change of sync_in realigns the timebase. If the input is first sampled high at clock edge k, then after clock edge k+1 the timebase shows p equal to the clamped offset and frame_idx equal to 0.
- R9: In listen direction, a sync_in held high or falling to low does not move the timebase. Only a new rising edge does.
- R10: After the last realignment the timebase free-runs. The next mfrm_start comes 48 × FRAME_BITS − offset clocks after the load, and later ones come at the full multiframe period.
- R11: With sync_dir = 0, transitions of sync_in have no effect on the indices or strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_dir | input | 1 | 0: drive sync pulse, 1: listen for sync edges |
| sync_offset | input | $clog2(FRAME_BITS) | Bit position in frame 0 for the sync event |
| sync_in | input | 1 | Multiframe sync from the system bus |
| sync_out | output | 1 | One-clock multiframe sync pulse |
| frame_start | output | 1 | Strobe at bit 0 of every frame |
| mfrm_start | output | 1 | Strobe at bit 0 of frame 0 |
| bit_idx | output | 3 | Bit within the current slot |
| slot_idx | output | $clog2(ceil(FRAME_BITS/8)) | Slot within the current frame |
| frame_idx | output | $clog2(FRAMES) | Frame within the multiframe |

## Verification
Indices and strobes are decoded straight from the counter registers, so each one changes right after the clock edge that moves the counter. The bench advances a reference position by one on every rising edge and compares all outputs at the following falling edge. A sync input edge needs two edges to take effect: one to sample it and one to load the offset. The bench therefore raises sync_in at a falling edge, lets one edge pass as a normal advance, and applies the load to its reference on the second edge. The sync pulse's frame and bit position are recorded in the same sampled cycle and compared with the expected offset.

// File: rtl/mf_timebase_pkg.sv
package mf_timebase_pkg;
  typedef enum logic {
    SYNC_DRIVE  = 1'b0,
    SYNC_LISTEN = 1'b1
  } sync_dir_e;

  localparam int unsigned SLOT_BITS_DEF = 8;
  localparam int unsigned FRAMES_DEF    = 48;
endpackage

// File: rtl/mf_edge_sense.sv
module mf_edge_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic din,
  output logic rise
);
  logic smp_q, prev_q;
  logic smp_d, prev_d;

  always_comb begin
    smp_d  = din;
    prev_d = smp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      smp_q  <= smp_d;
      prev_q <= prev_d;
    end
  end

  assign rise = enable & smp_q & ~prev_q;
endmodule

// File: rtl/mf_position_ctr.sv
module mf_position_ctr #(
  parameter int unsigned FRAME_BITS = 193,
  parameter int unsigned SLOT_BITS  = 8,
  parameter int unsigned FRAMES     = 48,
  localparam int unsigned PW    = $clog2(FRAME_BITS),
  localparam int unsigned SLOTS = (FRAME_BITS + SLOT_BITS - 1) / SLOT_BITS,
  localparam int unsigned SW    = $clog2(SLOTS),
  localparam int unsigned BW    = $clog2(SLOT_BITS),
  localparam int unsigned FW    = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PW-1:0] load_pos,
  output logic [PW-1:0] pos,
  output logic [BW-1:0] bit_no,
  output logic [SW-1:0] slot_no,
  output logic [FW-1:0] frame_no
);
  localparam logic [PW-1:0] POS_LAST   = PW'(FRAME_BITS - 1);
  localparam logic [BW-1:0] BIT_LAST   = BW'(SLOT_BITS - 1);
  localparam logic [FW-1:0] FRAME_LAST = FW'(FRAMES - 1);

  logic [PW-1:0] pos_q, pos_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [SW-1:0] slot_q, slot_d;
  logic [FW-1:0] frame_q, frame_d;
  logic          adv_en;

  assign adv_en = 1'b1;

  always_comb begin
    pos_d   = pos_q;
    bit_d   = bit_q;
    slot_d  = slot_q;
    frame_d = frame_q;
    if (load) begin
      pos_d   = load_pos;
      bit_d   = BW'(load_pos % PW'(SLOT_BITS));
      slot_d  = SW'(load_pos / PW'(SLOT_BITS));
      frame_d = '0;
    end else if (adv_en) begin
      if (pos_q == POS_LAST) begin
        pos_d   = '0;
        bit_d   = '0;
        slot_d  = '0;
        frame_d = (frame_q == FRAME_LAST) ? '0 : frame_q + 1'b1;
      end else begin
        pos_d = pos_q + 1'b1;
        if (bit_q == BIT_LAST) begin
          bit_d  = '0;
          slot_d = slot_q + 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= '0;
      bit_q   <= '0;
      slot_q  <= '0;
      frame_q <= '0;
    end else begin
      pos_q   <= pos_d;
      bit_q   <= bit_d;
      slot_q  <= slot_d;
      frame_q <= frame_d;
    end
  end

  assign pos      = pos_q;
  assign bit_no   = bit_q;
  assign slot_no  = slot_q;
  assign frame_no = frame_q;
endmodule

// File: rtl/mf_sync_decode.sv
module mf_sync_decode
  import mf_timebase_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 193,
  parameter int unsigned FRAMES     = 48,
  localparam int unsigned PW = $clog2(FRAME_BITS),
  localparam int unsigned FW = $clog2(FRAMES)
) (
  input  sync_dir_e     dir,
  input  logic [PW-1:0] pos,
  input  logic [FW-1:0] frame_no,
  input  logic [PW-1:0] offset,
  output logic          sync_pulse,
  output logic          frm_strobe,
  output logic          mf_strobe
);
  logic at_frame0;

  always_comb begin
    at_frame0  = (frame_no == '0);
    frm_strobe = (pos == '0);
    mf_strobe  = frm_strobe & at_frame0;
    sync_pulse = (dir == SYNC_DRIVE) & at_frame0 & (pos == offset);
  end
endmodule

// File: rtl/mf_timebase.sv
module mf_timebase
  import mf_timebase_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 193,
  parameter int unsigned FRAMES     = FRAMES_DEF,
  localparam int unsigned SLOT_BITS = SLOT_BITS_DEF,
  localparam int unsigned PW    = $clog2(FRAME_BITS),
  localparam int unsigned SLOTS = (FRAME_BITS + SLOT_BITS - 1) / SLOT_BITS,
  localparam int unsigned SW    = $clog2(SLOTS),
  localparam int unsigned BW    = $clog2(SLOT_BITS),
  localparam int unsigned FW    = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_dir,
  input  logic [PW-1:0] sync_offset,
  input  logic          sync_in,
  output logic          sync_out,
  output logic          frame_start,
  output logic          mfrm_start,
  output logic [BW-1:0] bit_idx,
  output logic [SW-1:0] slot_idx,
  output logic [FW-1:0] frame_idx
);
  localparam logic [PW-1:0] POS_MAX = PW'(FRAME_BITS - 1);

  sync_dir_e     dir;
  logic [PW-1:0] offset_c;
  logic [PW-1:0] pos;
  logic          realign;

  assign dir      = sync_dir_e'(sync_dir);
  assign offset_c = (sync_offset > POS_MAX) ? POS_MAX : sync_offset;

  mf_edge_sense u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (dir == SYNC_LISTEN),
    .din    (sync_in),
    .rise   (realign)
  );

  mf_position_ctr #(
    .FRAME_BITS (FRAME_BITS),
    .SLOT_BITS  (SLOT_BITS),
    .FRAMES     (FRAMES)
  ) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (realign),
    .load_pos (offset_c),
    .pos      (pos),
    .bit_no   (bit_idx),
    .slot_no  (slot_idx),
    .frame_no (frame_idx)
  );

  mf_sync_decode #(
    .FRAME_BITS (FRAME_BITS),
    .FRAMES     (FRAMES)
  ) u_dec (
    .dir        (dir),
    .pos        (pos),
    .frame_no   (frame_idx),
    .offset     (offset_c),
    .sync_pulse (sync_out),
    .frm_strobe (frame_start),
    .mf_strobe  (mfrm_start)
  );
endmodule

// File: rtl/mf_timebase_chk.sv
module mf_timebase_chk #(
  parameter int unsigned FRAME_BITS = 193,
  parameter int unsigned FRAMES     = 48,
  localparam int unsigned PW    = $clog2(FRAME_BITS),
  localparam int unsigned SLOTS = (FRAME_BITS + 7) / 8,
  localparam int unsigned SW    = $clog2(SLOTS),
  localparam int unsigned FW    = $clog2(FRAMES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_dir,
  input logic [PW-1:0] sync_offset,
  input logic          sync_in,
  input logic          sync_out,
  input logic          frame_start,
  input logic          mfrm_start,
  input logic [2:0]    bit_idx,
  input logic [SW-1:0] slot_idx,
  input logic [FW-1:0] frame_idx
);
  logic [PW-1:0] exp_off;
  assign exp_off = (sync_offset > PW'(FRAME_BITS - 1)) ? PW'(FRAME_BITS - 1) : sync_offset;

  AST_FRAME_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start); // R3

  AST_SYNC_OUT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |=> !sync_out); // R5

  AST_LISTEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sync_dir |-> !sync_out); // R7

  AST_FRAME_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(sync_dir) && !sync_dir && frame_start)
      |-> (frame_idx == FW'(($past(frame_idx) + 1) % FRAMES))); // R2

  AST_REALIGN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_dir && $past(sync_in) && !$past(sync_in, 2) && $stable(sync_offset))
      |=> (frame_idx == '0 && bit_idx == 3'(exp_off % 8) && slot_idx == SW'(exp_off / 8))); // R8
endmodule

bind mf_timebase mf_timebase_chk #(
  .FRAME_BITS (FRAME_BITS),
  .FRAMES     (FRAMES)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sync_dir    (sync_dir),
  .sync_offset (sync_offset),
  .sync_in     (sync_in),
  .sync_out    (sync_out),
  .frame_start (frame_start),
  .mfrm_start  (mfrm_start),
  .bit_idx     (bit_idx),
  .slot_idx    (slot_idx),
  .frame_idx   (frame_idx)
);

// File: tb/mf_timebase_test.sv
`timescale 1ns/1ps
module mf_timebase_test;
  localparam int FB = 193;
  localparam int NF = 48;
  localparam int MF = FB * NF;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sync_dir;
  logic [7:0] sync_offset;
  logic       sync_in;
  logic       sync_out, frame_start, mfrm_start;
  logic [2:0] bit_idx;
  logic [4:0] slot_idx;
  logic [5:0] frame_idx;

  int n_chk = 0;
  int n_bad = 0;
  int ep, ef;
  int sync_cnt, sync_pos, sync_frm, mf_cnt, fs_cnt;
  bit finished = 0;

  always #10 clk = ~clk;

  mf_timebase uut (
    .clk(clk), .rst_n(rst_n), .sync_dir(sync_dir), .sync_offset(sync_offset),
    .sync_in(sync_in), .sync_out(sync_out), .frame_start(frame_start),
    .mfrm_start(mfrm_start), .bit_idx(bit_idx), .slot_idx(slot_idx),
    .frame_idx(frame_idx)
  );

  function automatic int clampv(input int v);
    return (v > FB - 1) ? FB - 1 : v;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit load);
    @(posedge clk);
    if (load) begin
      ep = clampv(int'(sync_offset));
      ef = 0;
    end else if (ep == FB - 1) begin
      ep = 0;
      ef = (ef == NF - 1) ? 0 : ef + 1;
    end else begin
      ep++;
    end
    @(negedge clk);
  endtask

  task automatic cmp_all(input string req);
    chk({req, " bit_idx"}, int'(bit_idx), ep % 8);
    chk({req, " slot_idx"}, int'(slot_idx), ep / 8);
    chk({req, " frame_idx"}, int'(frame_idx), ef);
    chk("R3 frame_start", int'(frame_start), int'(ep == 0));
    chk("R4 mfrm_start", int'(mfrm_start), int'(ep == 0 && ef == 0));
  endtask

  task automatic run(input int n, input string req);
    sync_cnt = 0; mf_cnt = 0; fs_cnt = 0; sync_pos = -1; sync_frm = -1;
    for (int i = 0; i < n; i++) begin
      step(1'b0);
      cmp_all(req);
      if (sync_out) begin sync_cnt++; sync_pos = ep; sync_frm = ef; end
      if (mfrm_start) mf_cnt++;
      if (frame_start) fs_cnt++;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; sync_dir = 1'b0; sync_offset = 8'd5; sync_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 bit_idx", int'(bit_idx), 0);
    chk("R1 slot_idx", int'(slot_idx), 0);
    chk("R1 frame_idx", int'(frame_idx), 0);
    chk("R1 frame_start", int'(frame_start), 1);
    chk("R1 mfrm_start", int'(mfrm_start), 1);
    rst_n = 1'b1;
    ep = 0; ef = 0;
    chk("R1 frame_idx after release", int'(frame_idx), 0);
  endtask

  task automatic t_drive_run;
    run(2 * MF, "R2");
    chk("R3 frame count", fs_cnt, 2 * NF);
    chk("R4 multiframe count", mf_cnt, 2);
    chk("R5 sync pulses", sync_cnt, 2);
    chk("R5 sync position", sync_pos, 5);
    chk("R5 sync frame", sync_frm, 0);
  endtask

  task automatic t_clamp;
    sync_offset = 8'd250;
    run(MF, "R6");
    chk("R6 sync pulses", sync_cnt, 1);
    chk("R6 clamped position", sync_pos, FB - 1);
  endtask

  task automatic t_drive_ignore;
    sync_offset = 8'd5;
    sync_in = 1'b1;
    run(20, "R11");
    sync_in = 1'b0;
    run(20, "R11");
    sync_in = 1'b1;
    run(20, "R11");
    sync_in = 1'b0;
    chk("R11 frame_idx kept", int'(frame_idx), ef);
  endtask

  task automatic t_listen;
    sync_dir = 1'b1;
    sync_offset = 8'd37;
    run(30, "R7");
    sync_in = 1'b1;
    step(1'b0);
    step(1'b1);
    cmp_all("R8");
    chk("R8 position at offset", int'(slot_idx) * 8 + int'(bit_idx), 37);
    chk("R8 frame zero", int'(frame_idx), 0);
    run(500, "R9 held high");
    sync_in = 1'b0;
    run(300, "R9 after fall");
    sync_in = 1'b1;
    step(1'b0);
    step(1'b1);
    cmp_all("R8 second edge");
    sync_in = 1'b0;
    sync_cnt = 0;
    run(MF - 37, "R10");
    chk("R10 first mfrm_start at end of window", int'(mfrm_start), 1);
    chk("R10 one multiframe start", mf_cnt, 1);
    chk("R7 no sync_out in listen", sync_cnt, 0);
    run(MF, "R10");
    chk("R10 next multiframe", mf_cnt, 1);
    chk("R10 realigned last at end", int'(mfrm_start), 1);
  endtask

  task automatic t_listen_clamp;
    sync_offset = 8'd240;
    sync_in = 1'b1;
    step(1'b0);
    step(1'b1);
    cmp_all("R6 listen");
    chk("R6 listen load clamped", int'(slot_idx) * 8 + int'(bit_idx), FB - 1);
    sync_in = 1'b0;
    run(10, "R6");
  endtask

  initial begin
    t_reset();
    t_drive_run();
    t_clamp();
    t_drive_ignore();
    t_listen();
    t_listen_clamp();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule